// File: doc/BRIEF.md
# Fault Status Latch and Reporter

This block drives one active-high fault status line for a serially commanded output-driver controller. It watches single-cycle event pulses from the serial interface: chip select falling (frame start), serial clock rising, serial clock falling and chip select rising. From these it counts clock positions within each frame and detects frames that are too short or too long. It also watches per-channel short-circuit flags, an overtemperature flag and a standby indication from the command logic.

Each kind of fault is handled differently. Shorts and standby show on the status line only while they are present. Frame-length errors and overtemperature are held in latches. Each latch is released at its own clock position of a later frame, so a host that watches when the line drops can tell which fault was reported. After reset the line stays high until the first correctly sized frame completes.

Top module: `fault_status_reporter`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, status_o is 1. All fault latches start cleared.
- R2: The power-on indication keeps status_o high until a chip-select rising edge ends a frame that had exactly FRAME_BITS (8) falling clock edges and no more than FRAME_BITS rising edges. After that, status_o is 0 if no other condition is active.
- R3: While standby_i is 1, status_o is 1. The effect is combinational and nothing is latched.
- R4: While any bit of short_i is 1, status_o is 1. The effect is combinational, ends when the flags clear, and needs no clock-position release.
- R5: A frame that ends with fewer than 8 falling clock edges sets the short-frame latch, which is visible on status_o one cycle after the chip-select rising pulse. The latch is released by the 8th falling clock edge of a following frame.
- R6: The 9th rising clock edge of a frame sets the long-frame latch, which is visible one cycle after that edge's pulse. The latch is released by the 2nd falling clock edge of a following frame.
- R7: overtemp_i set to 1 sets the overtemperature latch, which stays set after the input drops. The latch is released by the 4th falling clock edge of a frame only if overtemp_i is 0 in that cycle.
- R8: When a set condition and a release event of the same latch fall in the same cycle, the set wins and the latch stays 1.
- R9: Clock positions count from 1 at the first falling edge after frame start and restart every frame. Clock edges and chip-select rising pulses that arrive outside a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | One-cycle pulse: chip select fell, a frame begins |
| sclk_rise_i | input | 1 | One-cycle pulse: serial clock rose |
| sclk_fall_i | input | 1 | One-cycle pulse: serial clock fell |
| cs_rise_i | input | 1 | One-cycle pulse: chip select rose, frame ends |
| short_i | input | CHANNELS | Live short-circuit flag per driver channel |
| overtemp_i | input | 1 | Live overtemperature flag |
| standby_i | input | 1 | All driver channels commanded off |
| status_o | output | 1 | Active-high fault status |

## Verification
The overtemperature latch can be set and released in the same cycle. This happens when overtemp_i is still 1 during the 4th falling clock pulse of a frame. The bench provokes it by holding overtemp_i high across exactly that pulse and dropping it immediately afterward. At that point only the latch can keep status_o high, and the line must stay high until the 4th falling edge of the next frame. Two other release windows are also checked one position before and at the release position: the long-frame latch is released by the 2nd falling edge and the short-frame latch by the 8th.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int FSR_CHANNELS   = 8;
    localparam int FSR_FRAME_BITS = 8;
    localparam int FSR_OVER_REL   = 2;
    localparam int FSR_OT_REL     = 4;

    typedef struct packed {
        logic por;
        logic under;
        logic over;
        logic ot;
    } fsr_latch_t;

    function automatic int pos_width(input int frame_bits);
        return $clog2(frame_bits + 2);
    endfunction

    // set has priority over a release in the same cycle
    function automatic logic latch_next(input logic q, input logic set, input logic rel);
        return set | (q & ~rel);
    endfunction

endpackage

// File: rtl/fsr_edge_counter.sv
module fsr_edge_counter #(
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             evt,
    input  logic             active,
    output logic             evt_ok,
    output logic [POS_W-1:0] cnt_o,
    output logic [POS_W-1:0] pos_o
);
    localparam logic [POS_W-1:0] MAXV = '1;
    localparam logic [POS_W-1:0] ONE  = POS_W'(1);

    logic [POS_W-1:0] cnt_q;
    logic [POS_W-1:0] inc;

    assign inc    = (cnt_q == MAXV) ? MAXV : cnt_q + ONE;
    assign evt_ok = evt & (active | clr);
    assign pos_o  = clr ? ONE : inc;
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= evt ? ONE : '0;
        end else if (evt_ok) begin
            cnt_q <= inc;
        end
    end

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        (clr && evt) |=> (cnt_o == ONE)); // R9
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!active && !clr) |=> $stable(cnt_o)); // R9

endmodule

// File: rtl/fsr_frame_err.sv
module fsr_frame_err #(
    parameter int POS_W      = 4,
    parameter int FRAME_BITS = 8,
    parameter int OVER_REL   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fall_ok,
    input  logic [POS_W-1:0] fall_pos,
    input  logic             rise_ok,
    input  logic [POS_W-1:0] rise_pos,
    input  logic             cs_rise_ok,
    input  logic [POS_W-1:0] fall_cnt,
    input  logic [POS_W-1:0] rise_cnt,
    output logic             under_q,
    output logic             over_q,
    output logic             xfer_ok
);
    import fsr_pkg::*;

    localparam logic [POS_W-1:0] FULL      = POS_W'(FRAME_BITS);
    localparam logic [POS_W-1:0] OVER_POS  = POS_W'(FRAME_BITS + 1);
    localparam logic [POS_W-1:0] OVER_RELP = POS_W'(OVER_REL);

    logic under_set, under_rel, over_set, over_rel;

    assign under_set = cs_rise_ok && (fall_cnt < FULL);
    assign under_rel = fall_ok && (fall_pos == FULL);
    assign over_set  = rise_ok && (rise_pos == OVER_POS);
    assign over_rel  = fall_ok && (fall_pos == OVER_RELP);
    assign xfer_ok   = cs_rise_ok && (fall_cnt == FULL) && (rise_cnt <= FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            under_q <= 1'b0;
            over_q  <= 1'b0;
        end else begin
            under_q <= latch_next(under_q, under_set, under_rel);
            over_q  <= latch_next(over_q, over_set, over_rel);
        end
    end

    AST_UNDER_SET: assert property (@(posedge clk) disable iff (rst)
        (cs_rise_ok && fall_cnt < FULL) |=> under_q); // R5
    AST_UNDER_CLR: assert property (@(posedge clk) disable iff (rst)
        (under_q && fall_ok && fall_pos == FULL && !cs_rise_ok) |=> !under_q); // R5
    AST_OVER_SET: assert property (@(posedge clk) disable iff (rst)
        (rise_ok && rise_pos == OVER_POS) |=> over_q); // R6
    AST_OVER_CLR: assert property (@(posedge clk) disable iff (rst)
        (over_q && fall_ok && fall_pos == OVER_RELP && !rise_ok) |=> !over_q); // R6

endmodule

// File: rtl/fsr_ot_latch.sv
module fsr_ot_latch #(
    parameter int POS_W  = 4,
    parameter int OT_REL = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ot_i,
    input  logic             fall_ok,
    input  logic [POS_W-1:0] fall_pos,
    output logic             ot_q
);
    import fsr_pkg::*;

    localparam logic [POS_W-1:0] RELP = POS_W'(OT_REL);

    logic rel;
    assign rel = fall_ok && (fall_pos == RELP) && !ot_i;

    always_ff @(posedge clk) begin
        if (rst) ot_q <= 1'b0;
        else     ot_q <= latch_next(ot_q, ot_i, rel);
    end

    AST_OT_SET: assert property (@(posedge clk) disable iff (rst)
        ot_i |=> ot_q); // R8
    AST_OT_KEEP: assert property (@(posedge clk) disable iff (rst)
        (ot_q && !(fall_ok && fall_pos == RELP)) |=> ot_q); // R7

endmodule

// File: rtl/fault_status_reporter.sv
module fault_status_reporter #(
    parameter int CHANNELS   = fsr_pkg::FSR_CHANNELS,
    parameter int FRAME_BITS = fsr_pkg::FSR_FRAME_BITS,
    parameter int OVER_REL   = fsr_pkg::FSR_OVER_REL,
    parameter int OT_REL     = fsr_pkg::FSR_OT_REL
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_start_i,
    input  logic                sclk_rise_i,
    input  logic                sclk_fall_i,
    input  logic                cs_rise_i,
    input  logic [CHANNELS-1:0] short_i,
    input  logic                overtemp_i,
    input  logic                standby_i,
    output logic                status_o
);
    import fsr_pkg::*;

    localparam int POS_W = pos_width(FRAME_BITS);

    logic             in_frame_q;
    logic             cs_rise_ok;
    logic             fall_ok, rise_ok, xfer_ok;
    logic [POS_W-1:0] fall_cnt, fall_pos, rise_cnt, rise_pos;
    fsr_latch_t       lat;

    always_ff @(posedge clk) begin
        if (rst)                in_frame_q <= 1'b0;
        else if (frame_start_i) in_frame_q <= 1'b1;
        else if (cs_rise_i)     in_frame_q <= 1'b0;
    end

    assign cs_rise_ok = cs_rise_i & in_frame_q & ~frame_start_i;

    fsr_edge_counter #(.POS_W(POS_W)) u_fall_cnt (
        .clk(clk), .rst(rst), .clr(frame_start_i), .evt(sclk_fall_i),
        .active(in_frame_q), .evt_ok(fall_ok), .cnt_o(fall_cnt), .pos_o(fall_pos)
    );

    fsr_edge_counter #(.POS_W(POS_W)) u_rise_cnt (
        .clk(clk), .rst(rst), .clr(frame_start_i), .evt(sclk_rise_i),
        .active(in_frame_q), .evt_ok(rise_ok), .cnt_o(rise_cnt), .pos_o(rise_pos)
    );

    fsr_frame_err #(.POS_W(POS_W), .FRAME_BITS(FRAME_BITS), .OVER_REL(OVER_REL)) u_frame_err (
        .clk(clk), .rst(rst), .fall_ok(fall_ok), .fall_pos(fall_pos),
        .rise_ok(rise_ok), .rise_pos(rise_pos), .cs_rise_ok(cs_rise_ok),
        .fall_cnt(fall_cnt), .rise_cnt(rise_cnt),
        .under_q(lat.under), .over_q(lat.over), .xfer_ok(xfer_ok)
    );

    fsr_ot_latch #(.POS_W(POS_W), .OT_REL(OT_REL)) u_ot (
        .clk(clk), .rst(rst), .ot_i(overtemp_i), .fall_ok(fall_ok),
        .fall_pos(fall_pos), .ot_q(lat.ot)
    );

    always_ff @(posedge clk) begin
        if (rst)          lat.por <= 1'b1;
        else if (xfer_ok) lat.por <= 1'b0;
    end

    assign status_o = (|lat) | standby_i | (|short_i);

    AST_POR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (lat.por && !xfer_ok) |=> lat.por); // R2
    AST_POR_DROP: assert property (@(posedge clk) disable iff (rst)
        xfer_ok |=> !lat.por); // R2
    AST_STRAY_CS: assert property (@(posedge clk) disable iff (rst)
        (cs_rise_i && !in_frame_q && !frame_start_i && !lat.under) |=> !lat.under); // R9

endmodule

// File: tb/fault_status_reporter_tb.sv
module fault_status_reporter_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_start_i = 1'b0;
    logic       sclk_rise_i = 1'b0;
    logic       sclk_fall_i = 1'b0;
    logic       cs_rise_i = 1'b0;
    logic [7:0] short_i = 8'h00;
    logic       overtemp_i = 1'b0;
    logic       standby_i = 1'b0;
    logic       status_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    fault_status_reporter u_dut (
        .clk(clk), .rst(rst), .frame_start_i(frame_start_i),
        .sclk_rise_i(sclk_rise_i), .sclk_fall_i(sclk_fall_i),
        .cs_rise_i(cs_rise_i), .short_i(short_i), .overtemp_i(overtemp_i),
        .standby_i(standby_i), .status_o(status_o)
    );

    task automatic chk(input logic exp, input string tag);
        n_tests++;
        if (status_o !== exp) begin
            n_fail++;
            $display("FAIL %s: status_o=%b expected %b", tag, status_o, exp);
        end
    endtask

    task automatic p_start();
        @(negedge clk) frame_start_i = 1'b1;
        @(negedge clk) frame_start_i = 1'b0;
    endtask
    task automatic p_rise();
        @(negedge clk) sclk_rise_i = 1'b1;
        @(negedge clk) sclk_rise_i = 1'b0;
    endtask
    task automatic p_fall();
        @(negedge clk) sclk_fall_i = 1'b1;
        @(negedge clk) sclk_fall_i = 1'b0;
    endtask
    task automatic p_end();
        @(negedge clk) cs_rise_i = 1'b1;
        @(negedge clk) cs_rise_i = 1'b0;
    endtask
    task automatic frame(input int n);
        p_start();
        for (int i = 0; i < n; i++) begin
            p_rise();
            p_fall();
        end
        p_end();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(1'b1, "R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        chk(1'b1, "R1 after reset release");
        frame(5);
        chk(1'b1, "R2 short frame keeps power-on status");
    endtask

    task automatic t_por_release();
        frame(8);
        chk(1'b0, "R2 first valid frame clears status");
    endtask

    task automatic t_standby();
        @(negedge clk) standby_i = 1'b1;
        #1 chk(1'b1, "R3 standby raises status");
        @(negedge clk) standby_i = 1'b0;
        #1 chk(1'b0, "R3 standby not latched");
    endtask

    task automatic t_short();
        @(negedge clk) short_i = 8'h10;
        #1 chk(1'b1, "R4 short raises status");
        @(negedge clk) short_i = 8'h00;
        #1 chk(1'b0, "R4 short not latched");
    endtask

    task automatic t_under();
        p_start();
        for (int i = 0; i < 5; i++) begin
            p_rise();
            p_fall();
        end
        chk(1'b0, "R5 before frame end");
        p_end();
        chk(1'b1, "R5 short frame latched at chip-select rise");
        p_start();
        for (int i = 1; i <= 8; i++) begin
            p_rise();
            p_fall();
            if (i < 8) chk(1'b1, $sformatf("R5 held after fall %0d", i));
            else       chk(1'b0, "R5 released at fall 8");
        end
        p_end();
        chk(1'b0, "R5 valid frame stays clear");
    endtask

    task automatic t_over();
        p_start();
        for (int i = 1; i <= 10; i++) begin
            p_rise();
            if (i == 8) chk(1'b0, "R6 clear at rise 8");
            if (i == 9) chk(1'b1, "R6 set at rise 9");
            p_fall();
        end
        p_end();
        chk(1'b1, "R6 latched after frame");
        p_start();
        p_rise(); p_fall();
        chk(1'b1, "R6 held after fall 1");
        p_rise(); p_fall();
        chk(1'b0, "R6 released at fall 2");
        for (int i = 3; i <= 8; i++) begin
            p_rise(); p_fall();
        end
        p_end();
    endtask

    task automatic t_ot();
        @(negedge clk) overtemp_i = 1'b1;
        @(negedge clk) overtemp_i = 1'b0;
        chk(1'b1, "R7 overtemp latched after input drops");
        p_start();
        for (int i = 1; i <= 4; i++) begin
            p_rise(); p_fall();
            if (i == 3) chk(1'b1, "R7 held after fall 3");
            if (i == 4) chk(1'b0, "R7 released at fall 4");
        end
        for (int i = 5; i <= 8; i++) begin
            p_rise(); p_fall();
        end
        p_end();
    endtask

    task automatic t_ot_conflict();
        @(negedge clk) overtemp_i = 1'b1;
        p_start();
        for (int i = 1; i <= 3; i++) begin
            p_rise(); p_fall();
        end
        p_rise();
        @(negedge clk) sclk_fall_i = 1'b1;
        @(negedge clk) begin
            sclk_fall_i = 1'b0;
            overtemp_i  = 1'b0;
        end
        #1 chk(1'b1, "R8 set wins over release at fall 4");
        for (int i = 5; i <= 8; i++) begin
            p_rise(); p_fall();
        end
        p_end();
        chk(1'b1, "R8 still latched at frame end");
        frame(8);
        chk(1'b0, "R7 released in next frame");
    endtask

    task automatic t_outside();
        frame(3);
        chk(1'b1, "R9 short frame latched");
        for (int i = 0; i < 10; i++) begin
            p_rise(); p_fall();
        end
        chk(1'b1, "R9 edges outside frame ignored");
        p_start();
        for (int i = 1; i <= 8; i++) begin
            p_rise(); p_fall();
            if (i == 7) chk(1'b1, "R9 count restarts at 1");
            if (i == 8) chk(1'b0, "R9 release at position 8");
        end
        p_end();
        p_end();
        chk(1'b0, "R9 stray chip-select rise ignored");
    endtask

    initial begin
        t_reset();
        t_por_release();
        t_standby();
        t_short();
        t_under();
        t_over();
        t_ot();
        t_ot_conflict();
        t_outside();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule